// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for two hardware threads that share one core. Its storage array holds `2*HALF_DEPTH` target slots. While both threads are active, each thread owns one half as a private circular stack with its own top-of-stack pointer. While only one thread is active, that thread uses the whole array as one larger circular stack.

A mode change never clears or rewrites stored targets. Only the pointers are remapped. As a result, the surviving thread can predict targets that its now-idle sibling pushed. This is the cross-thread reuse that software defends against by filling the stack with safe targets through a run of calls.

Each thread has a push request (a call, carrying its return target) and a pop request (a return). The prediction for a thread is always the entry at its current top. A consumer takes it in the cycle it pops. A valid flag marks entries that have never been written since reset or the last flush.

Top module: `smt_ras`

## Requirements
- R1: After reset the block is in two-thread mode (`single_mode_o`=0, `solo_thr_o`=0), both `pred_vld_o` bits are 0 and both `pred_tgt_o` values are 0.
- R2: Mode is registered from `thr_active_i` and takes effect one cycle later. Both bits set selects two-thread mode. Exactly one bit set selects single-thread mode, with `solo_thr_o` equal to the index of the active thread. Neither bit set holds both the mode and the owner. Requests issued in the cycle of a change use the old mode.
- R3: In two-thread mode, thread t uses physical slots t*HALF_DEPTH to t*HALF_DEPTH+HALF_DEPTH-1, through a pointer as wide as the half-depth index. A push advances the pointer and then writes at the new slot. A pop moves the pointer back by one. `pred_tgt_o[t]` always shows the slot under thread t's pointer. Each thread's pointer starts at the last slot of its half.
- R4: Pointers wrap without error. A push onto a full stack overwrites the oldest entry. A pop past the bottom exposes the entry at the wrapped slot.
- R5: On entering single-thread mode, the owner's full-width pointer becomes {owner, owner's half pointer}, which is the same physical slot it pointed at before.
- R6: Stored targets survive every mode change. In single-thread mode, pops that run past the owner's half expose targets that the sibling pushed.
- R7: On returning to two-thread mode, the owner's half pointer takes the low bits of its full-width pointer. The sibling's pointer is unchanged from before the switch.
- R8: In single-thread mode, push and pop requests from the idle thread are ignored. Its `pred_tgt_o` and `pred_vld_o` keep showing its own unchanged slot.
- R9: A push and a pop from the same thread in one cycle predict the current top, write the new target into that same slot, and leave the pointer unchanged.
- R10: `flush_i` clears every valid bit at the next edge. It takes priority over a push in the same cycle: the data is written and the pointer moves, but the slot stays invalid.
- R11: `pred_vld_o[t]` is 0 whenever the selected slot has not been written since reset or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all valid bits |
| thr_active_i | input | 2 | Per-thread active (1) / idle (0) status |
| push_i | input | 2 | Per-thread call push request |
| push_tgt_i | input | 2*TGT_W | Per-thread return target to push |
| pop_i | input | 2 | Per-thread return pop request |
| pred_tgt_o | output | 2*TGT_W | Per-thread predicted return target |
| pred_vld_o | output | 2 | Predicted entry has been written |
| single_mode_o | output | 1 | 1 when in single-thread mode |
| solo_thr_o | output | 1 | Thread that owns the array in single-thread mode |

## Verification
The bench uses the default parameters, TGT_W=32 and HALF_DEPTH=16. With these values a 4-bit half pointer wraps after 16 pushes, and a 5-bit full pointer can reach the sibling's half within a single pop. This makes overflow, underflow and cross-thread reuse reachable in a few cycles. Directed sequences pin down literal targets for each of the following:
- swap (push and pop together),
- wrap,
- rebase on entering single-thread mode,
- restore on returning to two-thread mode,
- flush priority.

Weighted random activity then drives frequent mode changes and owner swaps against a reference model.

// File: rtl/smt_ras_pkg.sv
package smt_ras_pkg;
  localparam int unsigned NUM_THR = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic push, input logic pop);
    return ras_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/smt_ras_mode.sv
module smt_ras_mode (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] act_i,
  output logic       single_q_o,
  output logic       owner_q_o,
  output logic       single_d_o,
  output logic       owner_d_o
);
  always_comb begin
    single_d_o = single_q_o;
    owner_d_o  = owner_q_o;
    unique case (act_i)
      2'b11: single_d_o = 1'b0;
      2'b01: begin single_d_o = 1'b1; owner_d_o = 1'b0; end
      2'b10: begin single_d_o = 1'b1; owner_d_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q_o <= 1'b0;
      owner_q_o  <= 1'b0;
    end else begin
      single_q_o <= single_d_o;
      owner_q_o  <= owner_d_o;
    end
  end

  p_dual_both_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == 2'b11 |=> !single_q_o);
  p_single_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_i) == 1 |=> single_q_o && (owner_q_o == $past(act_i[1])));
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == 2'b00 |=> $stable(single_q_o) && $stable(owner_q_o));
endmodule

// File: rtl/smt_ras_ptr.sv
module smt_ras_ptr
  import smt_ras_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 16,
  localparam int unsigned HW = $clog2(HALF_DEPTH),
  localparam int unsigned PW = HW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  single_q_i,
  input  logic                  owner_q_i,
  input  logic                  single_d_i,
  input  logic                  owner_d_i,
  input  logic [1:0]            push_i,
  input  logic [1:0]            pop_i,
  output logic [1:0][PW-1:0]    top_idx_o,
  output logic [1:0]            wr_en_o,
  output logic [1:0][PW-1:0]    wr_idx_o
);
  logic [1:0][HW-1:0] hptr_q, hptr_n;
  logic [PW-1:0]      sptr_q, sptr_n;
  logic               leave_single, enter_single;

  always_comb begin
    hptr_n = hptr_q;
    sptr_n = sptr_q;
    for (int t = 0; t < NUM_THR; t++) begin
      logic    solo, en;
      logic [HW-1:0] h_inc, h_dec;
      logic [PW-1:0] s_inc, s_dec, cur;
      ras_op_e op;
      solo  = single_q_i && (owner_q_i == 1'(t));
      en    = !single_q_i || solo;
      op    = en ? decode_op(push_i[t], pop_i[t]) : OP_NONE;
      h_inc = hptr_q[t] + 1'b1;
      h_dec = hptr_q[t] - 1'b1;
      s_inc = sptr_q + 1'b1;
      s_dec = sptr_q - 1'b1;
      cur   = solo ? sptr_q : {1'(t), hptr_q[t]};
      top_idx_o[t] = cur;
      wr_en_o[t]   = (op == OP_PUSH) || (op == OP_SWAP);
      wr_idx_o[t]  = cur;
      if (op == OP_PUSH) wr_idx_o[t] = solo ? s_inc : {1'(t), h_inc};
      if (solo) begin
        if (op == OP_PUSH) sptr_n = s_inc;
        else if (op == OP_POP) sptr_n = s_dec;
      end else if (en) begin
        if (op == OP_PUSH) hptr_n[t] = h_inc;
        else if (op == OP_POP) hptr_n[t] = h_dec;
      end
    end
    // remap after the cycle's operations: save owner, then rebase new owner
    leave_single = single_q_i && (!single_d_i || (owner_d_i != owner_q_i));
    enter_single = single_d_i && (!single_q_i || (owner_d_i != owner_q_i));
    if (leave_single) hptr_n[owner_q_i] = sptr_n[HW-1:0];
    if (enter_single) sptr_n = {owner_d_i, hptr_n[owner_d_i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hptr_q <= '1;
      sptr_q <= '1;
    end else begin
      hptr_q <= hptr_n;
      sptr_q <= sptr_n;
    end
  end

  p_swap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_q_i && !single_d_i && push_i[0] && pop_i[0]) |=>
      top_idx_o[0] == $past(top_idx_o[0]));
  p_rebase_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(single_q_i) |-> top_idx_o[owner_q_i][PW-1] == owner_q_i);
  p_idle_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_q_i && single_d_i && (owner_d_i == owner_q_i)) |=>
      $stable(top_idx_o[~owner_q_i]));
  p_dual_in_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_q_i |-> (top_idx_o[0][PW-1] == 1'b0) && (top_idx_o[1][PW-1] == 1'b1));
endmodule

// File: rtl/smt_ras_array.sv
module smt_ras_array #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [1:0]               wr_en_i,
  input  logic [1:0][PW-1:0]       wr_idx_i,
  input  logic [1:0][DATA_W-1:0]   wr_data_i,
  input  logic [1:0][PW-1:0]       rd_idx_i,
  output logic [1:0][DATA_W-1:0]   rd_data_o,
  output logic [1:0]               rd_vld_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      vld_q <= '0;
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (wr_en_i[w]) begin
          mem_q[wr_idx_i[w]] <= wr_data_i[w];
          vld_q[wr_idx_i[w]] <= 1'b1;
        end
      end
      if (flush_i) vld_q <= '0;
    end
  end

  for (genvar r = 0; r < 2; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_idx_i[r]];
    assign rd_vld_o[r]  = vld_q[rd_idx_i[r]];
  end

  p_wr_disjoint_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0] && wr_en_i[1]) |-> wr_idx_i[0] != wr_idx_i[1]);
  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> rd_vld_o == 2'b00);
  p_write_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i[0] && !flush_i && !wr_en_i[1]) |=> vld_q[$past(wr_idx_i[0])]);
endmodule

// File: rtl/smt_ras.sv
module smt_ras #(
  parameter int unsigned TGT_W      = 32,
  parameter int unsigned HALF_DEPTH = 16,
  localparam int unsigned DEPTH = 2 * HALF_DEPTH,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [1:0]             thr_active_i,
  input  logic [1:0]             push_i,
  input  logic [1:0][TGT_W-1:0]  push_tgt_i,
  input  logic [1:0]             pop_i,
  output logic [1:0][TGT_W-1:0]  pred_tgt_o,
  output logic [1:0]             pred_vld_o,
  output logic                   single_mode_o,
  output logic                   solo_thr_o
);
  logic            single_q, owner_q, single_d, owner_d;
  logic [1:0][PW-1:0] top_idx, wr_idx;
  logic [1:0]      wr_en;

  smt_ras_mode u_mode (
    .clk_i, .rst_ni,
    .act_i      (thr_active_i),
    .single_q_o (single_q),
    .owner_q_o  (owner_q),
    .single_d_o (single_d),
    .owner_d_o  (owner_d)
  );

  smt_ras_ptr #(.HALF_DEPTH(HALF_DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .single_q_i (single_q),
    .owner_q_i  (owner_q),
    .single_d_i (single_d),
    .owner_d_i  (owner_d),
    .push_i, .pop_i,
    .top_idx_o  (top_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx)
  );

  smt_ras_array #(.DEPTH(DEPTH), .DATA_W(TGT_W)) u_array (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_tgt_i),
    .rd_idx_i  (top_idx),
    .rd_data_o (pred_tgt_o),
    .rd_vld_o  (pred_vld_o)
  );

  assign single_mode_o = single_q;
  assign solo_thr_o    = owner_q;

  p_swap_predicts_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_q && !single_d && push_i[1] && pop_i[1] && !flush_i) |=>
      pred_tgt_o[1] == $past(push_tgt_i[1]) && pred_vld_o[1]);
endmodule

// File: tb/tb_smt_ras.sv
module tb_smt_ras;
  localparam int CLK_PERIOD = 10;
  localparam int TGT_W = 32;
  localparam int HALF  = 16;
  localparam int DEPTH = 2 * HALF;

  logic clk = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic [1:0] thr_active_i = 2'b11, push_i = '0, pop_i = '0;
  logic [1:0][TGT_W-1:0] push_tgt_i = '0;
  logic [1:0][TGT_W-1:0] pred_tgt_o;
  logic [1:0] pred_vld_o;
  logic single_mode_o, solo_thr_o;

  smt_ras #(.TGT_W(TGT_W), .HALF_DEPTH(HALF)) dut (.*, .clk_i(clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [TGT_W-1:0] m_mem [DEPTH];
  bit m_vld [DEPTH];
  int m_h [2];
  int m_s;
  bit m_single, m_owner;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  task automatic m_reset();
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_vld[i] = 0; end
    m_h[0] = HALF - 1; m_h[1] = HALF - 1; m_s = DEPTH - 1;
    m_single = 0; m_owner = 0;
  endtask

  function automatic int m_idx(int t);
    return (m_single && m_owner == t) ? m_s : t * HALF + m_h[t];
  endfunction

  task automatic m_step(logic [1:0] act, logic [1:0] ps, logic [1:0] pp,
                        logic [1:0][TGT_W-1:0] tg, logic fl);
    int nh [2];
    int ns, idx;
    bit nsingle, nowner, solo, en;
    nh[0] = m_h[0]; nh[1] = m_h[1]; ns = m_s;
    for (int t = 0; t < 2; t++) begin
      solo = m_single && (m_owner == t);
      en = !m_single || solo;
      if (en) begin
        idx = m_idx(t);
        if (ps[t] && pp[t]) begin
          m_mem[idx] = tg[t]; m_vld[idx] = 1;
        end else if (ps[t]) begin
          if (solo) begin ns = (m_s + 1) % DEPTH; idx = ns; end
          else begin nh[t] = (m_h[t] + 1) % HALF; idx = t * HALF + nh[t]; end
          m_mem[idx] = tg[t]; m_vld[idx] = 1;
        end else if (pp[t]) begin
          if (solo) ns = (m_s + DEPTH - 1) % DEPTH;
          else nh[t] = (m_h[t] + HALF - 1) % HALF;
        end
      end
    end
    nsingle = m_single; nowner = m_owner;
    if (act == 2'b11) nsingle = 0;
    else if (act == 2'b01) begin nsingle = 1; nowner = 0; end
    else if (act == 2'b10) begin nsingle = 1; nowner = 1; end
    if (m_single && (!nsingle || nowner != m_owner)) nh[m_owner] = ns % HALF;
    if (nsingle && (!m_single || nowner != m_owner)) ns = nowner * HALF + nh[nowner];
    if (fl) for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    m_h[0] = nh[0]; m_h[1] = nh[1]; m_s = ns;
    m_single = nsingle; m_owner = nowner;
  endtask

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk("R2", "single_mode", 64'(single_mode_o), 64'(m_single));
    chk("R2", "solo_thr", 64'(solo_thr_o), 64'(m_owner));
    for (int t = 0; t < 2; t++) begin
      chk(tag, "pred_tgt", 64'(pred_tgt_o[t]), 64'(m_mem[m_idx(t)]));
      chk("R11", "pred_vld", 64'(pred_vld_o[t]), 64'(m_vld[m_idx(t)]));
    end
  endtask

  task automatic cyc(logic [1:0] act, logic [1:0] ps, logic [1:0] pp,
                     logic [TGT_W-1:0] t0, logic [TGT_W-1:0] t1, logic fl, string tag);
    logic [1:0][TGT_W-1:0] tg;
    tg[0] = t0; tg[1] = t1;
    thr_active_i = act; push_i = ps; pop_i = pp; push_tgt_i = tg; flush_i = fl;
    @(posedge clk);
    m_step(act, ps, pp, tg, fl);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; thr_active_i = 2'b11; push_i = '0; pop_i = '0; flush_i = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk("R1", "single_mode", 64'(single_mode_o), 0);
    chk("R1", "pred_vld", 64'(pred_vld_o), 0);
    chk("R1", "pred_tgt0", 64'(pred_tgt_o[0]), 0);
    chk("R1", "pred_tgt1", 64'(pred_tgt_o[1]), 0);
    compare_all("R1");

    // R9 swap, R11 never-written
    cyc(2'b11, 2'b01, 2'b00, 32'hA0A0, 0, 0, "R3");
    chk("R3", "push top", 64'(pred_tgt_o[0]), 64'h0000_A0A0);
    cyc(2'b11, 2'b01, 2'b01, 32'hB0B0, 0, 0, "R9");
    chk("R9", "swap top", 64'(pred_tgt_o[0]), 64'h0000_B0B0);
    cyc(2'b11, 2'b00, 2'b01, 0, 0, 0, "R9");
    chk("R11", "empty vld", 64'(pred_vld_o[0]), 0);

    // R4 wrap: 17 pushes then 16 pops returns to newest
    for (int i = 0; i < 17; i++) cyc(2'b11, 2'b01, 2'b00, 32'hC00 + i, 0, 0, "R4");
    chk("R4", "overwrite top", 64'(pred_tgt_o[0]), 64'hC10);
    for (int i = 0; i < 16; i++) cyc(2'b11, 2'b00, 2'b01, 0, 0, 0, "R4");
    chk("R4", "wrapped pop", 64'(pred_tgt_o[0]), 64'hC10);

    // R5/R6/R8/R7 cross-thread reuse
    do_reset();
    for (int i = 0; i < 16; i++) cyc(2'b11, 2'b10, 2'b00, 0, 32'hD00 + i, 0, "R3");
    cyc(2'b11, 2'b01, 2'b00, 32'hE1, 0, 0, "R3");
    cyc(2'b01, 2'b00, 2'b00, 0, 0, 0, "R5");
    chk("R2", "enter single", 64'(single_mode_o), 1);
    chk("R5", "rebased top", 64'(pred_tgt_o[0]), 64'hE1);
    cyc(2'b01, 2'b00, 2'b01, 0, 0, 0, "R6");
    chk("R6", "sibling target", 64'(pred_tgt_o[0]), 64'hD0F);
    cyc(2'b01, 2'b10, 2'b10, 0, 32'hFFF, 0, "R8");
    chk("R8", "idle ignored", 64'(pred_tgt_o[1]), 64'hD0F);
    cyc(2'b11, 2'b00, 2'b00, 0, 0, 0, "R7");
    chk("R7", "owner restored vld", 64'(pred_vld_o[0]), 0);
    chk("R7", "sibling kept", 64'(pred_tgt_o[1]), 64'hD0F);

    // R10 flush beats push
    cyc(2'b11, 2'b01, 2'b00, 32'h5A5A, 0, 1, "R10");
    chk("R10", "flush vs push vld", 64'(pred_vld_o[0]), 0);
    chk("R10", "flush data kept", 64'(pred_tgt_o[0]), 64'h5A5A);
    chk("R10", "flush sibling vld", 64'(pred_vld_o[1]), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] act;
      int r;
      r = int'($urandom % 10);
      act = (r < 6) ? 2'b11 : (r == 6) ? 2'b01 : (r == 7) ? 2'b10 : (r == 8) ? 2'b00 : 2'b11;
      cyc(act, 2'($urandom), 2'($urandom), $urandom, $urandom,
          ($urandom % 64) == 0, m_single ? "R5" : "R3");
    end
    summary();
  end
endmodule